// File: doc/BRIEF.md
# Configurable Arithmetic Cell for a Stripe Fabric

This block is the compute cell of one row in a coarse-grained reconfigurable array. It takes three data words and a 3-bit operation code, and it returns one word. The operation code comes from a configuration register outside the cell that holds it steady while data flows. There is no register inside the cell. A result settles within the same evaluation and moves straight on to the interconnect of the next row.

The operation set is small and fixed. It covers wrap-around add, subtract and multiply, an arithmetic right shift, and a two-way select steered by the third operand. Two forwarding codes copy either the first or the second operand. The idle code drives the output to all zeros, which keeps switching low in the rows below an unused cell. The data width is a parameter and must be a power of two, at least 2.

Top module: `sfu_cell`

## Requirements
- R1: With `cfg_op` = 3'b000 (idle), `fu_out` is all zeros for every operand value.
- R2: With `cfg_op` = 3'b001, `fu_out` equals (`in_a` + `in_b`) modulo 2^WIDTH.
- R3: With `cfg_op` = 3'b010, `fu_out` equals (`in_a` - `in_b`) modulo 2^WIDTH.
- R4: With `cfg_op` = 3'b011, `fu_out` equals the low WIDTH bits of the product `in_a` * `in_b`.
- R5: With `cfg_op` = 3'b100, `fu_out` equals `in_a`, taken as two's complement, shifted right arithmetically. The shift amount is the low log2(WIDTH) bits of `in_b`, and the result rounds toward minus infinity.
- R6: With `cfg_op` = 3'b101, `fu_out` equals `in_b` when bit 0 of `in_s` is 1 and `in_a` when it is 0.
- R7: With `cfg_op` = 3'b110, `fu_out` equals `in_a`.
- R8: With `cfg_op` = 3'b111, `fu_out` equals `in_b`.
- R9: Under every code other than 3'b101, the value of `in_s` has no effect on `fu_out`.
- R10: Add and multiply give the same `fu_out` when `in_a` and `in_b` are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_op | input | 3 | Operation code from the static configuration register |
| in_a | input | WIDTH | Operand 0 |
| in_b | input | WIDTH | Operand 1; also supplies the shift amount |
| in_s | input | WIDTH | Operand 2; bit 0 steers the select operation |
| fu_out | output | WIDTH | Combinational result |

## Verification
The embedded checks assume that the operands and the code carry known two-state values and that the code is stable during each evaluation. They also assume that WIDTH is a power of two, so that the shift amount field covers every shift up to WIDTH-1. The stimulus uses a 4-bit build and walks through every code, every pair of operands and every select value. It changes inputs only away from the sampling point, so each comparison sees settled values.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'b000,
    OP_ADD   = 3'b001,
    OP_SUB   = 3'b010,
    OP_MUL   = 3'b011,
    OP_SHR   = 3'b100,
    OP_SEL   = 3'b101,
    OP_FWD_A = 3'b110,
    OP_FWD_B = 3'b111
  } sfu_op_e;

endpackage

// File: rtl/sfu_arith.sv
module sfu_arith #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] diff_o,
  output logic [WIDTH-1:0] prod_o
);

  logic [2*WIDTH-1:0] prod_full;

  always_comb begin
    sum_o     = a_i + b_i;
    diff_o    = a_i - b_i;
    prod_full = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
    prod_o    = prod_full[WIDTH-1:0];
  end

  logic unused_prod_hi;
  assign unused_prod_hi = ^prod_full[2*WIDTH-1:WIDTH];

endmodule

// File: rtl/sfu_shift.sv
module sfu_shift #(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WIDTH-1:0] res_o
);

  logic [WIDTH-1:0] stage [0:AMT_W];

  assign stage[0] = val_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k]
                      ? {{STEP{stage[k][WIDTH-1]}}, stage[k][WIDTH-1:STEP]}
                      : stage[k];
  end

  assign res_o = stage[AMT_W];

  always_comb begin
    a_r5_sign_kept: assert (res_o[WIDTH-1] == val_i[WIDTH-1])
      else $error("shift changed sign bit");
  end

endmodule

// File: rtl/sfu_route.sv
module sfu_route #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             pick_b_i,
  output logic [WIDTH-1:0] sel_o
);

  assign sel_o = pick_b_i ? b_i : a_i;

endmodule

// File: rtl/sfu_cell.sv
module sfu_cell #(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       cfg_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_s,
  output logic [WIDTH-1:0] fu_out
);
  import sfu_pkg::*;

  localparam int AMT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] sum_w, diff_w, prod_w, shr_w, sel_w;
  sfu_op_e          op;

  assign op = sfu_op_e'(cfg_op);

  sfu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i(in_a), .b_i(in_b),
    .sum_o(sum_w), .diff_o(diff_w), .prod_o(prod_w)
  );

  sfu_shift #(.WIDTH(WIDTH)) u_shift (
    .val_i(in_a), .amt_i(in_b[AMT_W-1:0]), .res_o(shr_w)
  );

  sfu_route #(.WIDTH(WIDTH)) u_route (
    .a_i(in_a), .b_i(in_b), .pick_b_i(in_s[0]), .sel_o(sel_w)
  );

  logic unused_s;
  assign unused_s = ^in_s[WIDTH-1:1];

  always_comb begin
    unique case (op)
      OP_ADD:   fu_out = sum_w;
      OP_SUB:   fu_out = diff_w;
      OP_MUL:   fu_out = prod_w;
      OP_SHR:   fu_out = shr_w;
      OP_SEL:   fu_out = sel_w;
      OP_FWD_A: fu_out = in_a;
      OP_FWD_B: fu_out = in_b;
      default:  fu_out = '0;
    endcase
  end

  always_comb begin
    if (op == OP_IDLE)
      a_r1_idle_zero: assert (fu_out == '0) else $error("idle not zero");
    if (op == OP_SEL && in_s[0])
      a_r6_sel_b: assert (fu_out == in_b) else $error("select b wrong");
    if (op == OP_SEL && !in_s[0])
      a_r6_sel_a: assert (fu_out == in_a) else $error("select a wrong");
    if (op == OP_ADD)
      a_r2_add_wrap: assert (fu_out - in_b == in_a) else $error("add wrong");
    if (op == OP_SUB)
      a_r3_sub_wrap: assert (fu_out + in_b == in_a) else $error("sub wrong");
    if (op == OP_FWD_B)
      a_r8_fwd_b: assert (fu_out == in_b) else $error("fwd b wrong");
  end

endmodule

// File: tb/sfu_cell_tb.sv
module sfu_cell_tb_top;

  localparam int W = 4;
  localparam int N = 1 << W;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]   cfg_op = 3'b000;
  logic [W-1:0] in_a = '0, in_b = '0, in_s = '0;
  logic [W-1:0] fu_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sfu_cell #(.WIDTH(W)) dut_i (
    .cfg_op(cfg_op), .in_a(in_a), .in_b(in_b), .in_s(in_s), .fu_out(fu_out)
  );

  function automatic int sgn(input int v);
    return (v >= N/2) ? v - N : v;
  endfunction

  function automatic int expect_of(input int op, input int a, input int b, input int s);
    int sa, p;
    case (op)
      1: return (a + b) % N;
      2: return (a - b + N) % N;
      3: return (a * b) % N;
      4: begin
        sa = sgn(a);
        p  = 1 << (b % (1 << AW));
        if (sa >= 0) return (sa / p) % N;
        return (-((-sa + p - 1) / p) + N) % N;
      end
      5: return (s % 2 == 1) ? b : a;
      6: return a;
      7: return b;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (op=%0d a=%0d b=%0d s=%0d)",
               req, act, exp, cfg_op, in_a, in_b, in_s);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2 R10";
      2: return "R3";
      3: return "R4 R10";
      4: return "R5";
      5: return "R6";
      6: return "R7 R9";
      default: return "R8 R9";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2 check("R1", fu_out, 0);
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          for (int s = 0; s < N; s++) begin
            @(negedge clk);
            cfg_op = op[2:0]; in_a = a[W-1:0]; in_b = b[W-1:0]; in_s = s[W-1:0];
            #2;
            check(req_of(op), int'(fu_out), expect_of(op, a, b, s));
          end
        end
      end
    end
    for (int op = 1; op < 4; op += 2) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          int first;
          @(negedge clk);
          cfg_op = op[2:0]; in_a = a[W-1:0]; in_b = b[W-1:0]; in_s = '0;
          #2 first = int'(fu_out);
          @(negedge clk);
          in_a = b[W-1:0]; in_b = a[W-1:0];
          #2 check("R10", int'(fu_out), first);
        end
      end
    end
    for (int s = 0; s < N; s++) begin
      @(negedge clk);
      cfg_op = 3'b100; in_a = 4'b1001; in_b = 4'd1; in_s = s[W-1:0];
      #2 check("R9", int'(fu_out), 12);
      @(negedge clk);
      cfg_op = 3'b000;
      #2 check("R9", int'(fu_out), 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule